// File: doc/BRIEF.md
# Streaming Gray Tile Binarizer

This block takes a raster-order stream of 16-bit colour pixels, one byte at a time, and reduces every frame to a small binary image. Each pixel becomes a gray level equal to the plain sum of its three colour fields. The frame is cut into non-overlapping tiles. With the default parameters the frame is 320x240, the tiles are 20 wide by 15 tall, and the result is a 16x16 grid. Each tile is summed over a fixed lattice of 16 sampled pixels, and the sum is compared with a programmable threshold to give one bit.

The work is done as the bytes arrive. There is one running accumulator per tile column, so the block never holds a frame or even a full line. When the final pixel of a band of tiles arrives, the block captures that band's bits. It then emits them one per cycle, each with its grid index, while the next band is already being gathered. A one-cycle flag marks the end of every frame.

The output control is a three-state machine:
- `ST_GATHER`: the block waits for the end of a tile band.
- `ST_EMIT`: the block emits the captured band's bits.
- `ST_DONE`: a single cycle that marks the end of the frame.

Its transitions are:
- BAND_END (`ST_GATHER` to `ST_EMIT`): the last pixel of a tile band is accepted.
- ROW_OUT (`ST_EMIT` to `ST_GATHER`): the last column of a band that is not the final band has been emitted.
- FRAME_OUT (`ST_EMIT` to `ST_DONE`): the last column of the final band has been emitted.
- REARM (`ST_DONE` to `ST_GATHER`): always, after one cycle.

Top module: `gray_tile_binarizer`

## Requirements
- R1: A pixel is two accepted bytes. The first byte is bits 15:8 of the word and the second byte is bits 7:0. Reset returns the byte pairing to expecting a first byte.
- R2: The gray value of a word is red + green + blue. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0, each taken as an unsigned field value, so gray spans 0 to 125.
- R3: A tile's sum includes only the pixels at in-tile rows 0, 4, 8, 12 and in-tile columns 0, 5, 10, 15 (16 pixels). All other pixels have no effect.
- R4: A tile's bit is 1 when its sum is greater than or equal to the 11-bit `thresh`, and 0 when the sum is below it. `thresh` is used as it stands when the band's last pixel is accepted.
- R5: In the cycle after the last pixel of a tile band is accepted, `tile_bit_vld` rises. It stays high for 16 consecutive cycles, with `tile_idx` = band*16 + column and the columns in increasing order from 0.
- R6: All column sums restart from zero for each tile band, so a band's bits depend only on that band's pixels.
- R7: `frame_done` is high for exactly one cycle, the cycle right after the final bit of the last band.
- R8: Cycles with `byte_vld` low are ignored whatever `byte_in` holds. Idle gaps between bytes do not change any result.
- R9: Out of reset, `tile_bit_vld` and `frame_done` are low.
- R10: Pixels of the next band may arrive while a band is being emitted. The emitted bits are not altered and no pixel is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Pixel byte, first byte is the high half |
| byte_vld | input | 1 | `byte_in` is taken this cycle |
| thresh | input | 11 | Binarization threshold |
| tile_bit | output | 1 | Binary result for the tile at `tile_idx` |
| tile_bit_vld | output | 1 | `tile_bit` and `tile_idx` are valid |
| tile_idx | output | 8 | Band in upper 4 bits, column in lower 4 bits |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
A broken byte pairing swaps the halves of every word. The bench therefore uses a word whose swapped gray value falls on the other side of the threshold, so every bit of that frame flips at the first band's emission. A raster counter that slips moves the sample lattice or the band end. That shows as wrong bits, or as `tile_bit_vld` missing in the exact cycle after the band's last pixel, which is checked at every band. An accumulator that is not cleared shows up in the next band, when a dark band follows a bright one. A wrong state sequence shows as a bad index order or a misplaced `frame_done` within one frame.

// File: rtl/gray_tile_pkg.sv
package gray_tile_pkg;
    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_EMIT   = 2'd1,
        ST_DONE   = 2'd2
    } emit_state_t;

    localparam int GRAY_W   = 7;
    localparam int GRAY_MAX = 125;
endpackage

// File: rtl/rgb565_pair_gray.sv
module rgb565_pair_gray
    import gray_tile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        byte_in,
    input  logic              byte_vld,
    output logic              pix_vld,
    output logic [GRAY_W-1:0] gray
);
    logic       have_hi;
    logic [7:0] hi_q;
    logic [15:0] word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_hi <= 1'b0;
            hi_q    <= '0;
        end else if (byte_vld) begin
            if (!have_hi) begin
                hi_q    <= byte_in;
                have_hi <= 1'b1;
            end else begin
                have_hi <= 1'b0;
            end
        end
    end

    always_comb begin
        word    = {hi_q, byte_in};
        pix_vld = byte_vld & have_hi;
        gray    = GRAY_W'(word[15:11]) + GRAY_W'(word[10:5]) + GRAY_W'(word[4:0]);
    end

    assert_gray_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> (gray <= GRAY_W'(GRAY_MAX)));
endmodule

// File: rtl/raster_tile_tracker.sv
module raster_tile_tracker #(
    parameter int TILE_W  = 20,
    parameter int TILE_H  = 15,
    parameter int TILES_X = 16,
    parameter int TILES_Y = 16,
    parameter int SAMP_DX = 5,
    parameter int SAMP_DY = 4,
    localparam int TXW   = $clog2(TILE_W),
    localparam int TYW   = $clog2(TILE_H),
    localparam int COL_W = $clog2(TILES_X),
    localparam int ROW_W = $clog2(TILES_Y),
    localparam int SXW   = $clog2(SAMP_DX),
    localparam int SYW   = $clog2(SAMP_DY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld,
    output logic             samp,
    output logic [COL_W-1:0] tcol,
    output logic [ROW_W-1:0] trow,
    output logic             row_end,
    output logic             frame_end
);
    localparam logic [TXW-1:0]   TX_LAST  = TXW'(TILE_W - 1);
    localparam logic [TYW-1:0]   TY_LAST  = TYW'(TILE_H - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(TILES_X - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(TILES_Y - 1);
    localparam logic [SXW-1:0]   SX_LAST  = SXW'(SAMP_DX - 1);
    localparam logic [SYW-1:0]   SY_LAST  = SYW'(SAMP_DY - 1);

    logic [TXW-1:0] tx;
    logic [TYW-1:0] ty;
    logic [SXW-1:0] sxp;
    logic [SYW-1:0] syp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx   <= '0;
            ty   <= '0;
            sxp  <= '0;
            syp  <= '0;
            tcol <= '0;
            trow <= '0;
        end else if (pix_vld) begin
            if (tx == TX_LAST) begin
                tx  <= '0;
                sxp <= '0;
                if (tcol == COL_LAST) begin
                    tcol <= '0;
                    if (ty == TY_LAST) begin
                        ty   <= '0;
                        syp  <= '0;
                        trow <= (trow == ROW_LAST) ? '0 : trow + 1'b1;
                    end else begin
                        ty  <= ty + 1'b1;
                        syp <= (syp == SY_LAST) ? '0 : syp + 1'b1;
                    end
                end else begin
                    tcol <= tcol + 1'b1;
                end
            end else begin
                tx  <= tx + 1'b1;
                sxp <= (sxp == SX_LAST) ? '0 : sxp + 1'b1;
            end
        end
    end

    always_comb begin
        samp      = (sxp == '0) && (syp == '0);
        row_end   = (tx == TX_LAST) && (tcol == COL_LAST) && (ty == TY_LAST);
        frame_end = row_end && (trow == ROW_LAST);
    end

    assert_tile_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx <= TX_LAST) && (ty <= TY_LAST));
endmodule

// File: rtl/tile_sum_bank.sv
module tile_sum_bank
    import gray_tile_pkg::*;
#(
    parameter int TILE_W  = 20,
    parameter int TILE_H  = 15,
    parameter int TILES_X = 16,
    parameter int SAMP_DX = 5,
    parameter int SAMP_DY = 4,
    parameter int ACC_W   = 11,
    localparam int COL_W   = $clog2(TILES_X),
    localparam int SX_N    = (TILE_W + SAMP_DX - 1) / SAMP_DX,
    localparam int SY_N    = (TILE_H + SAMP_DY - 1) / SAMP_DY,
    localparam int MAX_SUM = SX_N * SY_N * GRAY_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_vld,
    input  logic               samp,
    input  logic [COL_W-1:0]   tcol,
    input  logic               row_end,
    input  logic [GRAY_W-1:0]  gray,
    input  logic [ACC_W-1:0]   thresh,
    output logic [TILES_X-1:0] ge
);
    for (genvar c = 0; c < TILES_X; c++) begin : g_col
        logic [ACC_W-1:0] acc;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (pix_vld && row_end) begin
                acc <= '0;
            end else if (pix_vld && samp && (tcol == COL_W'(c))) begin
                acc <= acc + ACC_W'(gray);
            end
        end

        assign ge[c] = (acc >= thresh);

        assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            acc <= ACC_W'(MAX_SUM));
    end
endmodule

// File: rtl/tile_row_emitter.sv
module tile_row_emitter
    import gray_tile_pkg::*;
#(
    parameter int TILES_X = 16,
    parameter int TILES_Y = 16,
    localparam int COL_W = $clog2(TILES_X),
    localparam int ROW_W = $clog2(TILES_Y),
    localparam int IDX_W = COL_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_vld,
    input  logic               row_end,
    input  logic               frame_end,
    input  logic [ROW_W-1:0]   trow,
    input  logic [TILES_X-1:0] ge,
    output logic               tile_bit,
    output logic               tile_bit_vld,
    output logic [IDX_W-1:0]   tile_idx,
    output logic               frame_done
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(TILES_X - 1);

    emit_state_t        state_q, state_d;
    logic [TILES_X-1:0] snap_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic               last_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATHER: if (pix_vld && row_end) state_d = ST_EMIT;
            ST_EMIT:   if (col_q == COL_LAST)  state_d = last_q ? ST_DONE : ST_GATHER;
            ST_DONE:   state_d = ST_GATHER;
            default:   state_d = ST_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GATHER;
            snap_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_GATHER && pix_vld && row_end) begin
                snap_q <= ge;
                row_q  <= trow;
                last_q <= frame_end;
                col_q  <= '0;
            end else if (state_q == ST_EMIT) begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    always_comb begin
        tile_bit_vld = (state_q == ST_EMIT);
        tile_bit     = tile_bit_vld & snap_q[col_q];
        tile_idx     = {row_q, col_q};
        frame_done   = (state_q == ST_DONE);
    end

    assert_emit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_bit_vld && $past(tile_bit_vld)) |-> (tile_idx == IDX_W'($past(tile_idx) + 1'b1)));
    assert_emit_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tile_bit_vld) |-> ($past(tile_idx[COL_W-1:0]) == COL_LAST));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(tile_bit_vld));
endmodule

// File: rtl/gray_tile_binarizer.sv
module gray_tile_binarizer
    import gray_tile_pkg::*;
#(
    parameter int TILE_W  = 20,
    parameter int TILE_H  = 15,
    parameter int TILES_X = 16,
    parameter int TILES_Y = 16,
    parameter int SAMP_DX = 5,
    parameter int SAMP_DY = 4,
    parameter int ACC_W   = 11,
    localparam int COL_W = $clog2(TILES_X),
    localparam int ROW_W = $clog2(TILES_Y),
    localparam int IDX_W = COL_W + ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       byte_in,
    input  logic             byte_vld,
    input  logic [ACC_W-1:0] thresh,
    output logic             tile_bit,
    output logic             tile_bit_vld,
    output logic [IDX_W-1:0] tile_idx,
    output logic             frame_done
);
    logic               pix_vld;
    logic [GRAY_W-1:0]  gray;
    logic               samp;
    logic [COL_W-1:0]   tcol;
    logic [ROW_W-1:0]   trow;
    logic               row_end;
    logic               frame_end;
    logic [TILES_X-1:0] ge;

    rgb565_pair_gray u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (byte_in),
        .byte_vld (byte_vld),
        .pix_vld  (pix_vld),
        .gray     (gray)
    );

    raster_tile_tracker #(
        .TILE_W (TILE_W), .TILE_H (TILE_H), .TILES_X (TILES_X), .TILES_Y (TILES_Y),
        .SAMP_DX(SAMP_DX), .SAMP_DY(SAMP_DY)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_vld   (pix_vld),
        .samp      (samp),
        .tcol      (tcol),
        .trow      (trow),
        .row_end   (row_end),
        .frame_end (frame_end)
    );

    tile_sum_bank #(
        .TILE_W (TILE_W), .TILE_H (TILE_H), .TILES_X (TILES_X),
        .SAMP_DX(SAMP_DX), .SAMP_DY(SAMP_DY), .ACC_W (ACC_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_vld (pix_vld),
        .samp    (samp),
        .tcol    (tcol),
        .row_end (row_end),
        .gray    (gray),
        .thresh  (thresh),
        .ge      (ge)
    );

    tile_row_emitter #(
        .TILES_X (TILES_X), .TILES_Y (TILES_Y)
    ) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_vld      (pix_vld),
        .row_end      (row_end),
        .frame_end    (frame_end),
        .trow         (trow),
        .ge           (ge),
        .tile_bit     (tile_bit),
        .tile_bit_vld (tile_bit_vld),
        .tile_idx     (tile_idx),
        .frame_done   (frame_done)
    );
endmodule

// File: tb/test_gray_tile_binarizer.sv
module test_gray_tile_binarizer;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 20, TH = 15, NX = 4, NY = 4;
    localparam int W = TW * NX, H = TH * NY, NT = NX * NY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_vld = 1'b0;
    logic [10:0] thresh = '0;
    logic       tile_bit, tile_bit_vld, frame_done;
    logic [3:0] tile_idx;

    int total = 0, bad = 0;
    int nbits, next_idx, order_bad, done_cnt, done_bad, byte_cnt;
    logic got [NT];
    logic prev_vld = 1'b0;
    logic [3:0] prev_idx = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gray_tile_binarizer #(.TILES_X(NX), .TILES_Y(NY)) i_gray_tile_binarizer (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .thresh(thresh), .tile_bit(tile_bit), .tile_bit_vld(tile_bit_vld),
        .tile_idx(tile_idx), .frame_done(frame_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tile_bit_vld) begin
                if (int'(tile_idx) != next_idx) order_bad++;
                got[tile_idx] = tile_bit;
                next_idx = int'(tile_idx) + 1;
                nbits++;
            end
            if (frame_done) begin
                done_cnt++;
                if (!(prev_vld && prev_idx == 4'(NT - 1))) done_bad++;
            end
            prev_vld = tile_bit_vld;
            prev_idx = tile_idx;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gray_of(input logic [15:0] w);
        return int'(w[15:11]) + int'(w[10:5]) + int'(w[4:0]);
    endfunction

    function automatic bit is_samp(input int x, input int y);
        return ((x % TW) % 5 == 0) && ((x % TW) < 16) && ((y % TH) % 4 == 0);
    endfunction

    // mode 0 white, 1 sampled black else white, 2 pure green, 3 hash, 4 bands alternate
    function automatic logic [15:0] pix(input int mode, input int x, input int y);
        case (mode)
            0: return 16'hFFFF;
            1: return is_samp(x, y) ? 16'h0000 : 16'hFFFF;
            2: return 16'h07E0;
            3: return 16'((x * 37 + y * 101 + x * y * 13) ^ (y << 9));
            default: return ((y / TH) % 2 == 0) ? 16'hFFFF : 16'h0000;
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit gapped);
        byte_in = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in = 8'hA5;
        byte_cnt++;
    endtask

    task automatic idle(input bit gapped);
        if (gapped) repeat ((byte_cnt * 5 + 1) % 4) @(negedge clk);
    endtask

    task automatic run_frame(input int mode, input int thr, input bit gapped, input string req);
        int exp_sum [NT];
        logic [15:0] w;
        thresh = 11'(thr);
        for (int t = 0; t < NT; t++) exp_sum[t] = 0;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                if (is_samp(x, y)) exp_sum[(y / TH) * NX + x / TW] += gray_of(pix(mode, x, y));
        nbits = 0; next_idx = 0; order_bad = 0; done_cnt = 0; done_bad = 0;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                w = pix(mode, x, y);
                send_byte(w[15:8], gapped);
                idle(gapped);
                send_byte(w[7:0], gapped);
                if (x == W - 1 && (y % TH) == TH - 1) begin
                    // R5: emission starts in the cycle after the band's last pixel
                    check(tile_bit_vld && int'(tile_idx) == (y / TH) * NX, "R5 start",
                          int'(tile_bit_vld) * 100 + int'(tile_idx), 100 + (y / TH) * NX);
                end
                idle(gapped);
            end
        end
        repeat (24) @(negedge clk);
        check(nbits == NT, "R5 count", nbits, NT);
        check(order_bad == 0, "R5 order", order_bad, 0);
        check(done_cnt == 1 && done_bad == 0, "R7 done", done_cnt * 10 + done_bad, 10);
        for (int t = 0; t < NT; t++)
            check(got[t] == (exp_sum[t] >= thr), req, int'(got[t]), int'(exp_sum[t] >= thr));
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!tile_bit_vld && !frame_done, "R9 reset", int'(tile_bit_vld) + int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tile_bit_vld && !frame_done, "R9 post-reset", int'(tile_bit_vld) + int'(frame_done), 0);
    endtask

    task automatic test_full_white;       // R2 max gray, R4 equality
        run_frame(0, 2000, 0, "R4 sum==thresh");
        run_frame(0, 2001, 0, "R4 sum<thresh");
    endtask

    task automatic test_lattice;          // R3 unsampled pixels ignored
        run_frame(1, 1, 0, "R3 lattice");
    endtask

    task automatic test_byte_order;       // R1 high byte first, R8 gaps
        run_frame(2, 1008, 1, "R1 order");
    endtask

    task automatic test_hash;             // R2 field sums, R10 overlap
        run_frame(3, 700, 0, "R2 R10 hash");
        run_frame(3, 1100, 1, "R8 gapped hash");
    endtask

    task automatic test_bands;            // R6 band independence
        run_frame(4, 1, 0, "R6 band clear");
    endtask

    task automatic test_phase_reset;      // R1 pairing restarts at reset
        send_byte(8'h3C, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(2, 1008, 0, "R1 phase reset");
    endtask

    initial begin
        byte_cnt = 0;
        test_reset();
        test_full_white();
        test_lattice();
        test_byte_order();
        test_hash();
        test_bands();
        test_phase_reset();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule